// File: doc/BRIEF.md
# Digit-Range Binary/BCD Adder-Subtractor

This block is a single-pass combinational datapath. It adds or subtracts two 56-bit words, seen as fourteen 4-bit digits, in either plain binary or packed decimal (BCD). The operation touches only one contiguous window of digits, chosen by a low and a high digit index. Digits outside the window copy the first operand straight to the result. A carry input enters at the bottom digit of the window, and the carry leaving the top digit of the window appears on `carry_out`.

Subtraction complements the second operand one digit at a time. Binary mode uses the bitwise inverse of each nibble, and BCD mode uses nine minus the digit. The complemented value is then added, so a true difference needs `carry_in` = 1. A `carry_out` of 1 after a subtraction means no borrow occurred.

Inside, each digit evaluates two complete candidate sums at once: one assumes an incoming carry of 0 and the other a carry of 1. The carry-outs of these two candidates feed a flat lookahead network, which works out each digit's real carry-in and picks the matching candidate.

Top module: `digit_range_addsub`

## Requirements
- R1: With `bcd_mode`=0 and `subtract`=0, the window field of `result` equals the low bits of opa_field + opb_field + `carry_in`. Here a field is digits lo..hi, and digit i is bits [4i+3:4i]. `carry_out` is the bit just above the field.
- R2: With `bcd_mode`=0 and `subtract`=1, the window field equals opa_field + (bitwise inverse of opb_field) + `carry_in`, and `carry_out` is the bit above the field. With `carry_in`=1 this is the true difference, and `carry_out`=1 means no borrow.
- R3: With `bcd_mode`=1 and `subtract`=0, and every operand nibble in 0..9, the window holds the decimal value (A + B + `carry_in`) mod 10^n, with n the window length in digits. `carry_out` is 1 exactly when that sum reaches 10^n.
- R4: With `bcd_mode`=1 and `subtract`=1, and every operand nibble in 0..9, the window holds (A + (10^n − 1 − B) + `carry_in`) mod 10^n, and `carry_out` is 1 exactly when that sum reaches 10^n.
- R5: Every result digit outside the window equals the same digit of `opa`.
- R6: When no digit lies in the window (`lo_idx` > effective high index, or `lo_idx` ≥ 14), `result` equals `opa` and `carry_out` equals `carry_in`.
- R7: A `hi_idx` above 13 acts as 13.
- R8: `carry_in` reaches only the lowest window digit. A one-digit window behaves as a single-digit adder, and its carry-out comes from that digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 56 | First operand; also the source of digits outside the window |
| opb | input | 56 | Second operand (subtrahend when subtracting) |
| bcd_mode | input | 1 | 1 = packed decimal digits, 0 = binary nibbles |
| subtract | input | 1 | 1 = complement opb before adding |
| lo_idx | input | 4 | Lowest digit of the window |
| hi_idx | input | 4 | Highest digit of the window (values above 13 act as 13) |
| carry_in | input | 1 | Carry into the lowest window digit |
| result | output | 56 | Window sum/difference, opa elsewhere |
| carry_out | output | 1 | Carry out of the highest window digit, or carry_in if the window is empty |

## Verification
The block holds no state, so any internal fault shows at the ports as soon as the inputs settle. A wrong generate or propagate term, or a faulty lookahead chain, corrupts a window digit above the faulty position. It also corrupts `carry_out`, but only for operand pairs that carry across that digit. Long ripple patterns such as all-F plus one, and 99…9 plus one, therefore sit next to random operands. Errors in decoding the window bounds show up as window-edge digits that are wrongly modified or wrongly copied from `opa`, and as a `carry_out` taken from the wrong digit. Empty, single-digit and clamped windows are driven on purpose to expose these.

// File: rtl/bcdr_pkg.sv
package bcdr_pkg;
  localparam int unsigned DIG_W = 4;

  typedef logic [DIG_W-1:0] digit_t;

  typedef struct packed {
    logic bcd;
    logic sub;
  } op_ctl_t;
endpackage

// File: rtl/bcdr_digit_slice.sv
// One digit: operand complement, binary add, decimal correction.
module bcdr_digit_slice
  import bcdr_pkg::*;
#(
  parameter bit CIN = 1'b0
) (
  input  digit_t  a,
  input  digit_t  b,
  input  op_ctl_t ctl,
  output digit_t  sum,
  output logic    cout
);
  logic [DIG_W:0] nine_raw;
  digit_t         b_eff;
  logic [DIG_W:0] bin_sum;
  logic           fix;

  // Stage 1: complement adder (9 - b computed as 9 + ~b + 1)
  always_comb begin
    nine_raw = {1'b0, 4'd9} + {1'b0, ~b} + 5'd1;
    if (ctl.sub) b_eff = ctl.bcd ? nine_raw[DIG_W-1:0] : ~b;
    else         b_eff = b;
  end

  // Stage 2: binary adder with the fixed carry-in of this copy
  always_comb begin
    bin_sum = {1'b0, a} + {1'b0, b_eff} + {{DIG_W{1'b0}}, CIN};
  end

  // Stage 3: decimal correction adder
  always_comb begin
    fix  = ctl.bcd && (bin_sum > 5'd9);
    sum  = bin_sum[DIG_W-1:0] + (fix ? 4'd6 : 4'd0);
    cout = fix | bin_sum[DIG_W];
  end
endmodule

// File: rtl/bcdr_digit_pair.sv
// Two carry-select candidates for one digit.
module bcdr_digit_pair
  import bcdr_pkg::*;
(
  input  digit_t  a,
  input  digit_t  b,
  input  op_ctl_t ctl,
  output digit_t  sum_c0,
  output digit_t  sum_c1,
  output logic    gen,
  output logic    prop
);
  digit_t sums  [2];
  logic   couts [2];

  for (genvar k = 0; k < 2; k++) begin : g_copy
    bcdr_digit_slice #(.CIN(k[0])) u_slice (
      .a    (a),
      .b    (b),
      .ctl  (ctl),
      .sum  (sums[k]),
      .cout (couts[k])
    );
  end

  assign sum_c0 = sums[0];
  assign sum_c1 = sums[1];
  assign gen    = couts[0];
  assign prop   = couts[1];
endmodule

// File: rtl/bcdr_range_decode.sv
// Turns the digit bounds into window masks.
module bcdr_range_decode #(
  parameter int unsigned NDIG = 14,
  localparam int unsigned IW  = $clog2(NDIG)
) (
  input  logic [IW-1:0]   lo_idx,
  input  logic [IW-1:0]   hi_idx,
  output logic [NDIG-1:0] in_win,
  output logic [NDIG-1:0] lo_hot,
  output logic [NDIG-1:0] hi_hot,
  output logic            empty
);
  localparam logic [IW-1:0] TOP = IW'(NDIG - 1);

  logic [IW-1:0] hi_eff;

  always_comb begin
    hi_eff = (hi_idx > TOP) ? TOP : hi_idx;
    for (int i = 0; i < NDIG; i++) begin
      in_win[i] = (IW'(i) >= lo_idx) && (IW'(i) <= hi_eff);
      lo_hot[i] = in_win[i] && (IW'(i) == lo_idx);
      hi_hot[i] = in_win[i] && (IW'(i) == hi_eff);
    end
    empty = ~|in_win;
  end
endmodule

// File: rtl/bcdr_lookahead.sv
// Flat lookahead: each digit carry is a sum of products over lower window digits.
module bcdr_lookahead #(
  parameter int unsigned NDIG = 14
) (
  input  logic [NDIG-1:0] gen,
  input  logic [NDIG-1:0] prop,
  input  logic [NDIG-1:0] in_win,
  input  logic [NDIG-1:0] lo_hot,
  input  logic            carry_in,
  output logic [NDIG-1:0] dig_cin
);
  logic [NDIG-1:0] la_carry;
  logic [NDIG-1:0] src;

  // carry emitted by digit j when it is the source of a chain
  always_comb begin
    for (int j = 0; j < NDIG; j++) begin
      src[j] = (in_win[j] & gen[j]) | (lo_hot[j] & carry_in & prop[j]);
    end
  end

  always_comb begin
    for (int i = 0; i < NDIG; i++) begin
      logic acc;
      acc = 1'b0;
      for (int j = 0; j < i; j++) begin
        logic term;
        term = src[j];
        for (int k = j + 1; k < i; k++) begin
          term = term & prop[k];
        end
        acc = acc | term;
      end
      la_carry[i] = acc & in_win[i];
    end
  end

  // per-digit 2:1 choice between external carry and lookahead carry
  always_comb begin
    for (int i = 0; i < NDIG; i++) begin
      dig_cin[i] = lo_hot[i] ? carry_in : la_carry[i];
    end
  end
endmodule

// File: rtl/digit_range_addsub.sv
module digit_range_addsub
  import bcdr_pkg::*;
#(
  parameter int unsigned NDIG = 14,
  localparam int unsigned IW  = $clog2(NDIG),
  localparam int unsigned W   = NDIG * DIG_W
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic          bcd_mode,
  input  logic          subtract,
  input  logic [IW-1:0] lo_idx,
  input  logic [IW-1:0] hi_idx,
  input  logic          carry_in,
  output logic [W-1:0]  result,
  output logic          carry_out
);
  op_ctl_t         ctl;
  logic [NDIG-1:0] gen, prop, in_win, lo_hot, hi_hot, dig_cin, dig_cout;
  logic            empty;
  digit_t          s0 [NDIG];
  digit_t          s1 [NDIG];

  assign ctl.bcd = bcd_mode;
  assign ctl.sub = subtract;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    bcdr_digit_pair u_pair (
      .a      (opa[d*DIG_W +: DIG_W]),
      .b      (opb[d*DIG_W +: DIG_W]),
      .ctl    (ctl),
      .sum_c0 (s0[d]),
      .sum_c1 (s1[d]),
      .gen    (gen[d]),
      .prop   (prop[d])
    );
  end

  bcdr_range_decode #(.NDIG(NDIG)) u_range (
    .lo_idx (lo_idx),
    .hi_idx (hi_idx),
    .in_win (in_win),
    .lo_hot (lo_hot),
    .hi_hot (hi_hot),
    .empty  (empty)
  );

  bcdr_lookahead #(.NDIG(NDIG)) u_la (
    .gen      (gen),
    .prop     (prop),
    .in_win   (in_win),
    .lo_hot   (lo_hot),
    .carry_in (carry_in),
    .dig_cin  (dig_cin)
  );

  // carry-select and pass-through of opa outside the window
  always_comb begin
    for (int d = 0; d < NDIG; d++) begin
      dig_cout[d] = dig_cin[d] ? prop[d] : gen[d];
      if (in_win[d]) result[d*DIG_W +: DIG_W] = dig_cin[d] ? s1[d] : s0[d];
      else           result[d*DIG_W +: DIG_W] = opa[d*DIG_W +: DIG_W];
    end
  end

  // 14:1 AND-OR selection of the top window digit's carry
  always_comb begin
    carry_out = empty ? carry_in : |(hi_hot & dig_cout);
  end
endmodule

// File: rtl/bcdr_checker.sv
module bcdr_checker #(
  parameter int unsigned NDIG = 14,
  localparam int unsigned IW  = $clog2(NDIG),
  localparam int unsigned W   = NDIG * 4
) (
  input logic [W-1:0]  opa,
  input logic [W-1:0]  opb,
  input logic          bcd_mode,
  input logic          subtract,
  input logic [IW-1:0] lo_idx,
  input logic [IW-1:0] hi_idx,
  input logic          carry_in,
  input logic [W-1:0]  result,
  input logic          carry_out
);
  logic [NDIG-1:0] win;
  logic            full_win, opa_ok, opb_ok;

  always_comb begin
    for (int i = 0; i < NDIG; i++) begin
      win[i] = (i >= int'(lo_idx)) && (i <= int'(hi_idx) || int'(hi_idx) >= NDIG);
    end
    full_win = &win;
    opa_ok = 1'b1;
    opb_ok = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (opa[i*4 +: 4] > 4'd9) opa_ok = 1'b0;
      if (opb[i*4 +: 4] > 4'd9) opb_ok = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < NDIG; i++) begin
      // R5
      outside_pass_chk: assert (win[i] || result[i*4 +: 4] == opa[i*4 +: 4])
        else $error("outside digit %0d changed", i);
    end
  end

  always_comb begin
    // R6
    empty_window_chk: assert (|win || (result == opa && carry_out == carry_in))
      else $error("empty window altered outputs");
  end

  always_comb begin
    // R1
    full_bin_add_chk: assert (!(full_win && !bcd_mode && !subtract) ||
                              {carry_out, result} == ({1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, carry_in}))
      else $error("full binary add mismatch");
  end

  always_comb begin
    for (int i = 0; i < NDIG; i++) begin
      // R3
      bcd_digit_range_chk: assert (!(bcd_mode && opa_ok && opb_ok) || result[i*4 +: 4] <= 4'd9)
        else $error("decimal digit %0d out of range", i);
    end
  end
endmodule

bind digit_range_addsub bcdr_checker #(.NDIG(NDIG)) u_chk (.*);

// File: tb/digit_range_addsub_tb.sv
module digit_range_addsub_tb;
  logic        clk;
  logic [55:0] opa, opb, result;
  logic        bcd_mode, subtract, carry_in, carry_out;
  logic [3:0]  lo_idx, hi_idx;
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  digit_range_addsub u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic void model(input logic [55:0] a, b, input bit bcd, sub,
                                input int lo, hi, input bit cin,
                                output logic [55:0] r, output bit co);
    longint unsigned a64, b64, r64, fa, fb, s, m, pw;
    int he, w;
    he  = (hi > 13) ? 13 : hi;
    a64 = {8'd0, a};
    b64 = {8'd0, b};
    r64 = a64;
    co  = cin;
    if (lo <= he) begin
      if (!bcd) begin
        w  = 4 * (he - lo + 1);
        m  = (64'd1 << w) - 64'd1;
        fa = (a64 >> (4 * lo)) & m;
        fb = (b64 >> (4 * lo)) & m;
        if (sub) fb = ~fb & m;
        s  = fa + fb + 64'(cin);
        co = s[w];
        r64 = (r64 & ~(m << (4 * lo))) | ((s & m) << (4 * lo));
      end else begin
        fa = 0; fb = 0; pw = 1;
        for (int d = he; d >= lo; d--) begin
          fa = fa * 10 + ((a64 >> (4 * d)) & 64'hF);
          fb = fb * 10 + ((b64 >> (4 * d)) & 64'hF);
          pw = pw * 10;
        end
        if (sub) fb = pw - 1 - fb;
        s  = fa + fb + 64'(cin);
        co = (s >= pw);
        s  = s % pw;
        for (int d = lo; d <= he; d++) begin
          r64 = (r64 & ~(64'hF << (4 * d))) | ((s % 10) << (4 * d));
          s   = s / 10;
        end
      end
    end
    r = r64[55:0];
  endfunction

  function automatic logic [55:0] rand_bcd();
    logic [55:0] v;
    for (int d = 0; d < 14; d++) v[d*4 +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  task automatic apply(input logic [55:0] a, b, input bit bcd, sub,
                       input int lo, hi, input bit cin, input string req);
    logic [55:0] er;
    bit          ec;
    @(posedge clk);
    opa = a; opb = b; bcd_mode = bcd; subtract = sub;
    lo_idx = 4'(lo); hi_idx = 4'(hi); carry_in = cin;
    model(a, b, bcd, sub, lo, hi, cin, er, ec);
    @(negedge clk);
    n_chk++;
    if (result !== er || carry_out !== ec) begin
      n_fail++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b", req, result, carry_out, er, ec);
    end
  endtask

  function automatic string tag(input bit bcd, sub, input int lo, hi);
    int he = (hi > 13) ? 13 : hi;
    if (lo > he) return "R6";
    if (bcd) return sub ? "R4" : "R3";
    return sub ? "R2" : "R1";
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    opa = '0; opb = '0; bcd_mode = 0; subtract = 0; lo_idx = 0; hi_idx = 13; carry_in = 0;
    #1;
    n_chk++;
    if (result !== 56'd0 || carry_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: idle result=%h carry=%b expected 0/0", result, carry_out);
    end
    // directed corner cases
    apply({56{1'b1}}, 56'd0, 0, 0, 0, 13, 1, "R1");            // full binary ripple
    apply(56'd5, 56'd7, 0, 1, 0, 13, 1, "R2");                 // borrow out
    apply(56'h99999999999999, 56'd0, 1, 0, 0, 13, 1, "R3");    // decimal ripple
    apply(56'd0, 56'd1, 1, 1, 0, 13, 1, "R4");                 // 0-1 decimal
    apply(56'h12345678901234, 56'h99999999999999, 1, 0, 3, 7, 1, "R5");
    apply(56'hFFFFFFFFFFFFFF, 56'hFFFFFFFFFFFFFF, 0, 0, 2, 5, 0, "R5");
    apply(56'h0123456789ABCD, 56'h55555555555555, 0, 0, 9, 2, 1, "R6");
    apply(56'h0123456789ABCD, 56'h55555555555555, 1, 1, 15, 15, 0, "R6");
    apply(56'h99999000000000, 56'h00001000000000, 1, 0, 10, 15, 0, "R7");
    apply({56{1'b1}}, 56'd1, 0, 0, 11, 14, 0, "R7");
    apply(56'h00000000900000, 56'h00000000900000, 1, 0, 5, 5, 1, "R8");
    apply(56'h0000000000F000, 56'h00000000000000, 0, 0, 3, 3, 1, "R8");
    apply(56'h00000000F0F000, 56'h0000000000F000, 0, 0, 4, 5, 1, "R8"); // cin only at lo
    // constrained random
    for (int n = 0; n < 600; n++) begin
      bit bcd = 1'($urandom);
      bit sub = 1'($urandom);
      int lo  = int'($urandom % 16);
      int hi  = int'($urandom % 16);
      bit cin = 1'($urandom);
      logic [55:0] a, b;
      if (n % 4 == 0) lo = 0;
      if (n % 4 == 1) hi = 13;
      if (bcd) begin a = rand_bcd(); b = rand_bcd(); end
      else begin a = {$urandom, $urandom}; b = {$urandom, $urandom}; end
      apply(a, b, bcd, sub, lo, hi, cin, tag(bcd, sub, lo, hi));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule